// File: doc/BRIEF.md
# Indirect Register Access Bridge for a Two-Wire Serial Core

This block gives a host one 64-bit command word through which it reaches the small byte-wide register set of a two-wire serial controller. The host writes a word carrying a start flag, a direction flag, a primary opcode, a three-bit register selector and a data byte. The bridge decodes the word, waits a fixed access time, performs the internal read or write, and then drops the start flag. On a read it also places the fetched byte in the low byte of the word. Software polls the word until the flag is low, then takes the result from the low byte.

Four internal registers sit behind the bridge. Data, control and clock-control are writable. Status is read-only. A reset selector puts control back to zero and status back to its idle code. The writable bytes drive outputs toward the serial engine. Only the extended opcode reaches the registers. Every other opcode or selector finishes at once and leaves the registers unchanged.

Top module: `regAccessBridge`

## Requirements
- R1: After reset the command word reads as all zeros, the data, control and clock-control bytes are zero, and a status read returns the idle code 0xF8.
- R2: A host write with bit 63 set starts an access. For a supported access, bit 63 reads back as 1 for exactly ACCESS_LAT cycles and is then 0.
- R3: Bit 56 set selects a read. On completion bits 7:0 hold the register byte, replacing what the host wrote there, and bits 62:8 keep their written value.
- R4: Bits 60:57 equal to 6 select the extended opcode. Bits 34:32 then pick the register: 1 is data, 2 is control, 3 is status on read and clock-control on write, and 7 is reset.
- R5: An extended write stores bits 7:0 of the word into the selected register. The word reads back unchanged apart from bit 63 being cleared.
- R6: A host write arriving while bit 63 is set is ignored. It changes neither the command word nor any register.
- R7: Any other opcode (including 0 to 4), and selectors 0, 4, 5 and 6 under the extended opcode, complete after one cycle. They change no register, and a read of them returns 0 in bits 7:0.
- R8: An access to selector 7, read or write, sets control to 0 and status to 0xF8. It leaves data and clock-control unchanged, and as a read it returns 0.
- R9: A host write with bit 63 clear only loads the word. It reads back exactly as written and starts no access.
- R10: A clock-control write does not alter the byte returned by a later status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe for the command word |
| hostWrData | input | 64 | Command word written by the host |
| hostRdData | output | 64 | Current command word, polled by the host |
| coreData | output | 8 | Data register toward the serial engine |
| coreCtl | output | 8 | Control register toward the serial engine |
| coreClkCtl | output | 8 | Clock-control register toward the serial engine |

## Verification
The bench builds the bridge with ACCESS_LAT set to 3. With that value the polled busy window, three cycles for a supported access, differs from the single cycle of an unsupported one, so a latency error or a mix-up in the decode shows up as a wrong cycle count. The busy window also gives the bench room to write a second word into the middle of an access and confirm that the word is dropped. The status idle code is kept at its default, so reset and the reset selector can be checked against 0xF8.

// File: rtl/regBridgePkg.sv
`timescale 1ns/1ps
package regBridgePkg;

  localparam int CMD_W     = 64;
  localparam int BYTE_W    = 8;
  localparam int VALID_BIT = 63;
  localparam int READ_BIT  = 56;
  localparam int OP_LSB    = 57;
  localparam int OP_W      = 4;
  localparam int SUB_LSB   = 32;
  localparam int SUB_W     = 3;
  // Decoded positions of the direct-transfer fields; these opcodes are not executed here
  localparam int EXT_IA_BIT   = 61;
  localparam int SIZE_OVR_BIT = 55;
  localparam int SIZE_LSB     = 52;
  localparam int SADDR_LSB    = 40;
  localparam int IADDR_LSB    = 32;

  typedef enum logic [OP_W-1:0] {
    OP_ADDR7     = 4'd0,
    OP_ADDR7_IA  = 4'd1,
    OP_ADDR10    = 4'd2,
    OP_ADDR10_IA = 4'd3,
    OP_BUSCLK    = 4'd4,
    OP_EXTENDED  = 4'd6
  } opCode_e;

  typedef enum logic [SUB_W-1:0] {
    SUB_DATA    = 3'd1,
    SUB_CTL     = 3'd2,
    SUB_STATCLK = 3'd3,
    SUB_RESET   = 3'd7
  } subSel_e;

  typedef struct packed {
    logic valid;
    logic isRead;
    logic supported;
    logic [SUB_W-1:0] sub;
  } cmdInfo_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic finish;
    logic wrData;
    logic wrCtl;
    logic wrClk;
    logic doReset;
    logic rdData;
    logic rdCtl;
    logic rdStat;
    logic capRead;
  } strobe_t;

  function automatic cmdInfo_t decodeCmd(input logic [CMD_W-1:0] word);
    cmdInfo_t info;
    logic [OP_W-1:0] op;
    op             = word[OP_LSB +: OP_W];
    info.valid     = word[VALID_BIT];
    info.isRead    = word[READ_BIT];
    info.sub       = word[SUB_LSB +: SUB_W];
    info.supported = 1'b0;
    if (op == OP_EXTENDED) begin
      case (info.sub)
        SUB_DATA, SUB_CTL, SUB_STATCLK, SUB_RESET: info.supported = 1'b1;
        default: info.supported = 1'b0;
      endcase
    end
    return info;
  endfunction

endpackage

// File: rtl/regBridgeCtrl.sv
`timescale 1ns/1ps
module regBridgeCtrl
  import regBridgePkg::*;
#(
  parameter int ACCESS_LAT = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostWrEn,
  input  logic [CMD_W-1:0] newWord,
  input  logic [CMD_W-1:0] curWord,
  output strobe_t          strb
);

  localparam int CNT_W = $clog2(ACCESS_LAT + 1);
  localparam logic [CNT_W-1:0] CNT_START = CNT_W'(ACCESS_LAT - 1);

  typedef enum logic {ST_IDLE, ST_WAIT} state_e;

  state_e stateQ;
  logic [CNT_W-1:0] cntQ;
  cmdInfo_t newInfo, curInfo;
  logic accept, start, lastCycle, doWrite;

  assign newInfo   = decodeCmd(newWord);
  assign curInfo   = decodeCmd(curWord);
  assign accept    = hostWrEn && (stateQ == ST_IDLE);
  assign start     = accept && newInfo.valid;
  assign lastCycle = (stateQ == ST_WAIT) && (cntQ == '0);
  assign doWrite   = lastCycle && curInfo.supported && !curInfo.isRead;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
    end else if (start) begin
      stateQ <= ST_WAIT;
      cntQ   <= newInfo.supported ? CNT_START : '0;
    end else if (lastCycle) begin
      stateQ <= ST_IDLE;
    end else if (stateQ == ST_WAIT) begin
      cntQ <= cntQ - 1'b1;
    end
  end

  always_comb begin
    strb         = '0;
    strb.load    = accept;
    strb.finish  = lastCycle;
    strb.capRead = lastCycle && curInfo.isRead;
    strb.wrData  = doWrite && (curInfo.sub == SUB_DATA);
    strb.wrCtl   = doWrite && (curInfo.sub == SUB_CTL);
    strb.wrClk   = doWrite && (curInfo.sub == SUB_STATCLK);
    strb.doReset = lastCycle && curInfo.supported && (curInfo.sub == SUB_RESET);
    if (lastCycle && curInfo.supported && curInfo.isRead) begin
      strb.rdData = (curInfo.sub == SUB_DATA);
      strb.rdCtl  = (curInfo.sub == SUB_CTL);
      strb.rdStat = (curInfo.sub == SUB_STATCLK);
    end
  end

  AST_BUSY_TRACKS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAIT) == curWord[VALID_BIT]); // R2

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAIT && cntQ != '0) |=> (stateQ == ST_WAIT && cntQ == $past(cntQ) - 1'b1)); // R2

  AST_UNSUP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (start && !newInfo.supported) |=> strb.finish); // R7

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strb.wrData, strb.wrCtl, strb.wrClk, strb.doReset,
                strb.rdData, strb.rdCtl, strb.rdStat}) <= 1); // R4

endmodule

// File: rtl/regBridgeDp.sv
`timescale 1ns/1ps
module regBridgeDp
  import regBridgePkg::*;
#(
  parameter logic [7:0] STAT_IDLE = 8'hF8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CMD_W-1:0]  hostWrData,
  input  strobe_t           strb,
  output logic [CMD_W-1:0]  cmdWord,
  output logic [BYTE_W-1:0] dataOut,
  output logic [BYTE_W-1:0] ctlOut,
  output logic [BYTE_W-1:0] clkCtlOut
);

  logic [CMD_W-1:0]  cmdReg;
  logic [BYTE_W-1:0] dataReg, ctlReg, clkReg, statReg, readByte, wrByte;

  assign wrByte = cmdReg[BYTE_W-1:0];

  always_comb begin
    readByte = '0;
    if (strb.rdData) readByte = dataReg;
    else if (strb.rdCtl) readByte = ctlReg;
    else if (strb.rdStat) readByte = statReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg <= '0;
    end else if (strb.load) begin
      cmdReg <= hostWrData;
    end else if (strb.finish) begin
      cmdReg[VALID_BIT] <= 1'b0;
      if (strb.capRead) cmdReg[BYTE_W-1:0] <= readByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg <= '0;
      ctlReg  <= '0;
      clkReg  <= '0;
      statReg <= STAT_IDLE;
    end else begin
      if (strb.wrData) dataReg <= wrByte;
      if (strb.wrClk) clkReg <= wrByte;
      if (strb.doReset) begin
        ctlReg  <= '0;
        statReg <= STAT_IDLE;
      end else if (strb.wrCtl) begin
        ctlReg <= wrByte;
      end
    end
  end

  assign cmdWord   = cmdReg;
  assign dataOut   = dataReg;
  assign ctlOut    = ctlReg;
  assign clkCtlOut = clkReg;

  AST_DONE_CLEARS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> !cmdReg[VALID_BIT]); // R2

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReg[VALID_BIT] && !strb.finish) |=> $stable(cmdReg)); // R6

  AST_UNSUP_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capRead && !(strb.rdData || strb.rdCtl || strb.rdStat))
      |=> (cmdReg[BYTE_W-1:0] == '0)); // R7

  AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (!rstN)
    strb.doReset |=> (ctlReg == '0 && statReg == STAT_IDLE)); // R8

  AST_REGS_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.finish |=> ($stable(dataReg) && $stable(ctlReg) && $stable(clkReg))); // R9

endmodule

// File: rtl/regAccessBridge.sv
`timescale 1ns/1ps
module regAccessBridge #(
  parameter int         ACCESS_LAT = 4,
  parameter logic [7:0] STAT_IDLE  = 8'hF8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWrEn,
  input  logic [63:0] hostWrData,
  output logic [63:0] hostRdData,
  output logic [7:0]  coreData,
  output logic [7:0]  coreCtl,
  output logic [7:0]  coreClkCtl
);
  import regBridgePkg::*;

  strobe_t strb;
  logic [CMD_W-1:0] cmdWord;

  regBridgeCtrl #(.ACCESS_LAT(ACCESS_LAT)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .hostWrEn(hostWrEn),
    .newWord (hostWrData),
    .curWord (cmdWord),
    .strb    (strb)
  );

  regBridgeDp #(.STAT_IDLE(STAT_IDLE)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .hostWrData(hostWrData),
    .strb      (strb),
    .cmdWord   (cmdWord),
    .dataOut   (coreData),
    .ctlOut    (coreCtl),
    .clkCtlOut (coreClkCtl)
  );

  assign hostRdData = cmdWord;

endmodule

// File: tb/test_regAccessBridge.sv
`timescale 1ns/1ps
module test_regAccessBridge;

  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [63:0] hostWrData = '0;
  logic [63:0] hostRdData;
  logic [7:0]  coreData, coreCtl, coreClkCtl;

  int applied = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  regAccessBridge #(.ACCESS_LAT(LAT), .STAT_IDLE(8'hF8)) i_regAccessBridge (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .coreData(coreData), .coreCtl(coreCtl),
    .coreClkCtl(coreClkCtl)
  );

  typedef struct packed {
    logic [63:0] cmd;
    logic [63:0] resp;
    logic [7:0]  cyc;
    logic [7:0]  d;
    logic [7:0]  c;
    logic [7:0]  k;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{64'h8C00_0001_0000_005A, 64'h0C00_0001_0000_005A, 8'd3, 8'h5A, 8'h00, 8'h00, 8'd5},  // R5 data write
    '{64'h8D00_0001_0000_0000, 64'h0D00_0001_0000_005A, 8'd3, 8'h5A, 8'h00, 8'h00, 8'd3},  // R3 data read
    '{64'h8C00_0002_0000_00C4, 64'h0C00_0002_0000_00C4, 8'd3, 8'h5A, 8'hC4, 8'h00, 8'd4},  // R4 control write
    '{64'h8D00_0002_0000_0000, 64'h0D00_0002_0000_00C4, 8'd3, 8'h5A, 8'hC4, 8'h00, 8'd4},  // R4 control read
    '{64'h8D00_0003_0000_0000, 64'h0D00_0003_0000_00F8, 8'd3, 8'h5A, 8'hC4, 8'h00, 8'd1},  // R1 status idle
    '{64'h8C00_0003_0000_002B, 64'h0C00_0003_0000_002B, 8'd3, 8'h5A, 8'hC4, 8'h2B, 8'd10}, // R10 clock-control write
    '{64'h8D00_0003_0000_0000, 64'h0D00_0003_0000_00F8, 8'd3, 8'h5A, 8'hC4, 8'h2B, 8'd10}, // R10 status unaffected
    '{64'h8D00_0001_0000_0077, 64'h0D00_0001_0000_005A, 8'd3, 8'h5A, 8'hC4, 8'h2B, 8'd3},  // R3 low byte replaced
    '{64'h8C00_0007_0000_0011, 64'h0C00_0007_0000_0011, 8'd3, 8'h5A, 8'h00, 8'h2B, 8'd8},  // R8 reset write
    '{64'h8D00_0002_0000_0000, 64'h0D00_0002_0000_0000, 8'd3, 8'h5A, 8'h00, 8'h2B, 8'd8},  // R8 control zero
    '{64'h8100_0000_0000_0033, 64'h0100_0000_0000_0000, 8'd1, 8'h5A, 8'h00, 8'h2B, 8'd7},  // R7 opcode 0 read
    '{64'h8C00_0005_0000_0099, 64'h0C00_0005_0000_0099, 8'd1, 8'h5A, 8'h00, 8'h2B, 8'd7},  // R7 selector 5 write
    '{64'h8800_0001_0000_00AA, 64'h0800_0001_0000_00AA, 8'd1, 8'h5A, 8'h00, 8'h2B, 8'd7},  // R7 opcode 4 write
    '{64'h8C00_0002_0000_0081, 64'h0C00_0002_0000_0081, 8'd3, 8'h5A, 8'h81, 8'h2B, 8'd5},  // R5 control write
    '{64'h8D00_0007_0000_0055, 64'h0D00_0007_0000_0000, 8'd3, 8'h5A, 8'h00, 8'h2B, 8'd8}   // R8 reset read
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doCmd(input logic [63:0] w, output int cyc);
    @(negedge clk);
    hostWrEn   = 1'b1;
    hostWrData = w;
    @(negedge clk);
    hostWrEn = 1'b0;
    cyc = 0;
    while (hostRdData[63] && cyc < 200) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    int cyc;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 word", hostRdData, 64'h0);
    check("R1 data", {56'h0, coreData}, 64'h0);
    check("R1 ctl", {56'h0, coreCtl}, 64'h0);
    check("R1 clkctl", {56'h0, coreClkCtl}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      doCmd(VEC[i].cmd, cyc);
      check({tag, " resp"}, hostRdData, VEC[i].resp);
      check({tag, " cycles R2"}, 64'(cyc), 64'(VEC[i].cyc));
      check({tag, " data"}, {56'h0, coreData}, {56'h0, VEC[i].d});
      check({tag, " ctl"}, {56'h0, coreCtl}, {56'h0, VEC[i].c});
      check({tag, " clkctl"}, {56'h0, coreClkCtl}, {56'h0, VEC[i].k});
    end

    // R6: second host write during a busy read is dropped
    @(negedge clk);
    hostWrEn   = 1'b1;
    hostWrData = 64'h8D00_0001_0000_0000;
    @(negedge clk);
    hostWrData = 64'h8C00_0001_0000_0011;
    check("R6 busy", {63'h0, hostRdData[63]}, 64'h1);
    @(negedge clk);
    hostWrEn = 1'b0;
    check("R6 word held", hostRdData, 64'h8D00_0001_0000_0000);
    cyc = 0;
    while (hostRdData[63] && cyc < 200) begin
      cyc++;
      @(negedge clk);
    end
    check("R6 resp", hostRdData, 64'h0D00_0001_0000_005A);
    check("R6 data kept", {56'h0, coreData}, 64'h5A);

    // R9: word without valid flag only loads
    @(negedge clk);
    hostWrEn   = 1'b1;
    hostWrData = 64'h0C00_0002_0000_00EE;
    @(negedge clk);
    hostWrEn = 1'b0;
    check("R9 word", hostRdData, 64'h0C00_0002_0000_00EE);
    repeat (LAT + 1) @(negedge clk);
    check("R9 word stays", hostRdData, 64'h0C00_0002_0000_00EE);
    check("R9 ctl", {56'h0, coreCtl}, 64'h0);
    doCmd(64'h8D00_0002_0000_0000, cyc);
    check("R9 next read", hostRdData, 64'h0D00_0002_0000_0000);
    check("R9 next cycles R2", 64'(cyc), 64'(LAT));

    summary();
  end

endmodule